// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits between an asynchronous flash-style bus and a separate program/erase engine. It samples the bus enables (chip, write, latch and output enable, all active low) with a system clock. From the rising edges it recovers each bus write cycle: the address and the command or data word. Each captured word is then interpreted as part of a one-cycle or two-cycle instruction.

Some instructions only change what subsequent reads return. This block does not carry the read data. It drives a read-source code that a downstream read multiplexer uses. Other instructions clear the status error flag. Block erase and buffered program are two-cycle sequences. Each ends with a one-cycle strobe carrying the target address and, for a program, the word count. An invalid second cycle aborts the sequence, raises the error flag and returns reads to the array.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A bus write cycle is recognised only while chip, write and latch enables are all low and output enable is high. With output enable low, toggling the other enables has no effect on any output.
- R2: The command/data word is taken on the first rise of write enable or chip enable, whichever comes first. A later rise of the other enable does not produce a second command.
- R3: The address is taken on the first rise among latch, write and chip enable. If latch enable rises first, address changes after that rise are ignored.
- R4: Read-mode opcodes (low data byte) set `readSrc`. 0xFF selects array (code 0), 0x90 selects signature (1), 0x70 selects status (2), 0x98 selects query (3) and 0x94 selects block protection (4).
- R5: Opcode 0x50 is a single-cycle command that clears `statusErr`.
- R6: Opcode 0x20 followed by a second cycle whose low byte is 0xD0 pulses `eraseStb` for one cycle, with `opAddr` equal to the second cycle's address. After the first cycle, `readSrc` is status (2) and no strobe has been issued.
- R7: Opcode 0xE8 followed by a second cycle whose data is a count below MAX_WORDS (32) pulses `progStb` for one cycle. `opAddr` is the second cycle's address and `opCount` is the count. After the first cycle, `readSrc` is status (2).
- R8: A second cycle that is not valid gives no strobe, sets `statusErr`, sets `readSrc` to array (0) and returns the sequencer to idle. For erase, invalid means a low byte other than 0xD0. For program, invalid means a count of MAX_WORDS or more.
- R9: After reset, `readSrc` is array (0), `statusErr` is 0 and both strobes are low.
- R10: An unrecognised first-cycle opcode leaves `readSrc`, `statusErr` and both strobes unchanged.
- R11: A decoded result appears two clock edges after the first edge that samples the ending enable high. Each strobe lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busCeN | input | 1 | Bus chip enable, active low |
| busOeN | input | 1 | Bus output enable, active low |
| busWeN | input | 1 | Bus write enable, active low |
| busLeN | input | 1 | Bus latch enable, active low |
| busAddr | input | 16 | Bus address |
| busData | input | 16 | Bus write data |
| readSrc | output | 3 | Read source: 0 array, 1 signature, 2 status, 3 query, 4 protection |
| statusErr | output | 1 | Status register sequence-error flag |
| eraseStb | output | 1 | One-cycle block erase request |
| progStb | output | 1 | One-cycle buffered program request |
| opAddr | output | 16 | Address for the erase or program request |
| opCount | output | 5 | Word count for the program request |

## Verification
A stuck sequencer state shows up at the next bus write. If the sequencer stays armed after a first cycle, a later read-mode opcode is taken as a bad confirm: `statusErr` rises and `readSrc` drops to array, two clock edges after that write ends. A wrong address-capture flag appears as the wrong `opAddr` on the next strobe. A capture stage that fails to clear its armed state shows as a duplicate or spurious command when the second enable rises. The bench checks results in the cycle where they should appear and also one cycle earlier, so a timing error of a single register is caught.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int OP_W   = 8;

  typedef enum logic [2:0] {
    SRC_ARRAY  = 3'd0,
    SRC_SIG    = 3'd1,
    SRC_STATUS = 3'd2,
    SRC_QUERY  = 3'd3,
    SRC_PROT   = 3'd4
  } readSrc_t;

  // One captured bus write, handed from capture logic to the sequencer
  typedef struct packed {
    logic              valid;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } busCmd_t;
endpackage

// File: rtl/fcd_bus_capture.sv
module fcd_bus_capture
  import fcd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic              leN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output busCmd_t           cmd
);
  logic              sCe, sOe, sWe, sLe;
  logic [ADDR_W-1:0] sAddr;
  logic [DATA_W-1:0] sData;
  logic              armed, addrHeld;
  logic [ADDR_W-1:0] heldAddr;

  logic writeActive, inCycle, riseCe, riseWe, riseLe, commit, addrEdge;

  // A write phase opens when all three enables are low with output enable high
  assign writeActive = !sCe && !sWe && !sLe && sOe;
  assign inCycle     = armed || writeActive;
  assign riseCe      = !sCe && ceN;
  assign riseWe      = !sWe && weN;
  assign riseLe      = !sLe && leN;
  // Data is taken on whichever of write or chip enable rises first
  assign commit      = inCycle && (riseCe || riseWe);
  // Address is taken on the first rise of any of the three enables
  assign addrEdge    = inCycle && !addrHeld && (riseLe || riseWe || riseCe);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sCe      <= 1'b1;
      sOe      <= 1'b1;
      sWe      <= 1'b1;
      sLe      <= 1'b1;
      sAddr    <= '0;
      sData    <= '0;
      armed    <= 1'b0;
      addrHeld <= 1'b0;
      heldAddr <= '0;
      cmd      <= '0;
    end else begin
      sCe       <= ceN;
      sOe       <= oeN;
      sWe       <= weN;
      sLe       <= leN;
      sAddr     <= addr;
      sData     <= data;
      cmd.valid <= commit;
      if (commit) begin
        cmd.addr <= addrHeld ? heldAddr : sAddr;
        cmd.data <= sData;
        armed    <= 1'b0;
        addrHeld <= 1'b0;
      end else begin
        if (writeActive) armed <= 1'b1;
        if (addrEdge) begin
          heldAddr <= sAddr;
          addrHeld <= 1'b1;
        end
      end
    end
  end

  // R2: a command is only produced after write or chip enable was seen low
  a_r2_commit_from_low_enable: assert property (@(posedge clk) disable iff (!rstN)
    cmd.valid |-> ($past(!sCe) || $past(!sWe)));
  // R2: one bus cycle yields at most one command
  a_r2_single_command: assert property (@(posedge clk) disable iff (!rstN)
    cmd.valid |=> !cmd.valid);
endmodule

// File: rtl/fcd_cmd_seq.sv
module fcd_cmd_seq
  import fcd_pkg::*;
#(
  parameter int            MAX_WORDS  = 32,
  parameter logic [7:0]    OP_ARRAY   = 8'hFF,
  parameter logic [7:0]    OP_SIG     = 8'h90,
  parameter logic [7:0]    OP_STATUS  = 8'h70,
  parameter logic [7:0]    OP_QUERY   = 8'h98,
  parameter logic [7:0]    OP_PROT    = 8'h94,
  parameter logic [7:0]    OP_CLEAR   = 8'h50,
  parameter logic [7:0]    OP_ERASE   = 8'h20,
  parameter logic [7:0]    OP_CONFIRM = 8'hD0,
  parameter logic [7:0]    OP_BUFPROG = 8'hE8,
  localparam int           CNT_W      = $clog2(MAX_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCmd_t           cmd,
  output readSrc_t          readSrc,
  output logic              statusErr,
  output logic              eraseStb,
  output logic              progStb,
  output logic [ADDR_W-1:0] opAddr,
  output logic [CNT_W-1:0]  opCount
);
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ERASE, SEQ_BUF} seq_t;
  seq_t state;

  logic [OP_W-1:0] op;
  logic            countOk;
  assign op      = cmd.data[OP_W-1:0];
  assign countOk = cmd.data < DATA_W'(MAX_WORDS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= SEQ_IDLE;
      readSrc   <= SRC_ARRAY;
      statusErr <= 1'b0;
      eraseStb  <= 1'b0;
      progStb   <= 1'b0;
      opAddr    <= '0;
      opCount   <= '0;
    end else begin
      eraseStb <= 1'b0;
      progStb  <= 1'b0;
      if (cmd.valid) begin
        unique case (state)
          SEQ_IDLE: begin
            if      (op == OP_ARRAY)  readSrc <= SRC_ARRAY;
            else if (op == OP_SIG)    readSrc <= SRC_SIG;
            else if (op == OP_STATUS) readSrc <= SRC_STATUS;
            else if (op == OP_QUERY)  readSrc <= SRC_QUERY;
            else if (op == OP_PROT)   readSrc <= SRC_PROT;
            else if (op == OP_CLEAR)  statusErr <= 1'b0;
            else if (op == OP_ERASE) begin
              state   <= SEQ_ERASE;
              readSrc <= SRC_STATUS;
            end else if (op == OP_BUFPROG) begin
              state   <= SEQ_BUF;
              readSrc <= SRC_STATUS;
            end
          end
          SEQ_ERASE: begin
            state <= SEQ_IDLE;
            if (op == OP_CONFIRM) begin
              eraseStb <= 1'b1;
              opAddr   <= cmd.addr;
            end else begin
              statusErr <= 1'b1;
              readSrc   <= SRC_ARRAY;
            end
          end
          SEQ_BUF: begin
            state <= SEQ_IDLE;
            if (countOk) begin
              progStb <= 1'b1;
              opAddr  <= cmd.addr;
              opCount <= cmd.data[CNT_W-1:0];
            end else begin
              statusErr <= 1'b1;
              readSrc   <= SRC_ARRAY;
            end
          end
          default: state <= SEQ_IDLE;
        endcase
      end
    end
  end

  // R6/R7: never both requests at once
  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(eraseStb && progStb));
  // R6: an erase request follows only an armed erase sequence
  a_r6_erase_needs_setup: assert property (@(posedge clk) disable iff (!rstN)
    eraseStb |-> $past(state) == SEQ_ERASE);
  // R7: a program request follows only an armed buffer sequence
  a_r7_prog_needs_setup: assert property (@(posedge clk) disable iff (!rstN)
    progStb |-> $past(state) == SEQ_BUF);
  // R8: any second cycle returns the sequencer to idle
  a_r8_second_cycle_ends: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.valid && state != SEQ_IDLE) |=> state == SEQ_IDLE);
  // R11: strobes last one cycle
  a_r11_erase_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    eraseStb |=> !eraseStb);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int MAX_WORDS = 32,
  localparam int CNT_W    = $clog2(MAX_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busCeN,
  input  logic              busOeN,
  input  logic              busWeN,
  input  logic              busLeN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  output logic [2:0]        readSrc,
  output logic              statusErr,
  output logic              eraseStb,
  output logic              progStb,
  output logic [ADDR_W-1:0] opAddr,
  output logic [CNT_W-1:0]  opCount
);
  busCmd_t  cmd;
  readSrc_t src;

  fcd_bus_capture capture (
    .clk(clk), .rstN(rstN),
    .ceN(busCeN), .oeN(busOeN), .weN(busWeN), .leN(busLeN),
    .addr(busAddr), .data(busData), .cmd(cmd)
  );

  fcd_cmd_seq #(.MAX_WORDS(MAX_WORDS)) seq (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .readSrc(src), .statusErr(statusErr),
    .eraseStb(eraseStb), .progStb(progStb),
    .opAddr(opAddr), .opCount(opCount)
  );

  assign readSrc = src;
endmodule

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busCeN = 1'b1, busOeN = 1'b1, busWeN = 1'b1, busLeN = 1'b1;
  logic [15:0] busAddr = '0, busData = '0;
  logic [2:0]  readSrc;
  logic        statusErr, eraseStb, progStb;
  logic [15:0] opAddr;
  logic [4:0]  opCount;

  int total = 0, fails = 0;
  bit done = 0;

  // values seen one cycle early, on time, and one cycle late
  logic earlyErase, earlyProg, lateErase, lateProg;
  logic [2:0] earlySrc;
  logic snapErase, snapProg;
  logic [15:0] snapAddr;
  logic [4:0]  snapCount;

  flash_cmd_decoder uut (
    .clk(clk), .rstN(rstN), .busCeN(busCeN), .busOeN(busOeN),
    .busWeN(busWeN), .busLeN(busLeN), .busAddr(busAddr), .busData(busData),
    .readSrc(readSrc), .statusErr(statusErr), .eraseStb(eraseStb),
    .progStb(progStb), .opAddr(opAddr), .opCount(opCount)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // how: 0 write enable rises first, 1 chip enable rises first,
  //      2 latch enable rises first then address changes, 3 output enable held low
  task automatic busWrite(input logic [15:0] a, input logic [15:0] d,
                          input int how, input logic [15:0] lateAddr);
    @(negedge clk);
    busAddr = a; busData = d;
    busOeN = (how == 3) ? 1'b0 : 1'b1;
    busCeN = 1'b0; busLeN = 1'b0; busWeN = 1'b0;
    @(negedge clk); @(negedge clk);
    if (how == 2) begin
      busLeN = 1'b1;
      @(negedge clk);
      busAddr = lateAddr;
      @(negedge clk);
      busWeN = 1'b1;
    end else if (how == 1) begin
      busCeN = 1'b1;
    end else begin
      busWeN = 1'b1;
    end
    @(negedge clk);
    earlyErase = eraseStb; earlyProg = progStb; earlySrc = readSrc;
    @(negedge clk);
    snapErase = eraseStb; snapProg = progStb; snapAddr = opAddr; snapCount = opCount;
    busCeN = 1'b1; busWeN = 1'b1; busLeN = 1'b1; busOeN = 1'b1;
    @(negedge clk);
    lateErase = eraseStb; lateProg = progStb;
    @(negedge clk);
  endtask

  task automatic testReset;
    chk("R9 readSrc", readSrc, 0);
    chk("R9 statusErr", statusErr, 0);
    chk("R9 eraseStb", eraseStb, 0);
    chk("R9 progStb", progStb, 0);
  endtask

  task automatic testReadModes;
    busWrite(16'h0000, 16'h0090, 0, 0); chk("R4 signature", readSrc, 1);
    chk("R11 not early", earlySrc, 0);
    busWrite(16'h0000, 16'h0070, 0, 0); chk("R4 status", readSrc, 2);
    busWrite(16'h0000, 16'h0098, 0, 0); chk("R4 query", readSrc, 3);
    busWrite(16'h0000, 16'h0094, 0, 0); chk("R4 protection", readSrc, 4);
    busWrite(16'h0000, 16'hAAFF, 0, 0); chk("R4 array", readSrc, 0);
  endtask

  task automatic testUnknown;
    busWrite(16'h0000, 16'h0090, 0, 0);
    busWrite(16'h0010, 16'h0033, 0, 0);
    chk("R10 readSrc kept", readSrc, 1);
    chk("R10 no erase", snapErase, 0);
    chk("R10 no prog", snapProg, 0);
    chk("R10 err kept", statusErr, 0);
  endtask

  task automatic testErase;
    busWrite(16'h0000, 16'h0020, 0, 0);
    chk("R6 setup status", readSrc, 2);
    chk("R6 setup no strobe", snapErase, 0);
    busWrite(16'h1200, 16'h00D0, 0, 0);
    chk("R11 erase not early", earlyErase, 0);
    chk("R6 erase strobe", snapErase, 1);
    chk("R6 erase addr", snapAddr, 16'h1200);
    chk("R11 erase one cycle", lateErase, 0);
  endtask

  task automatic testProgram;
    busWrite(16'h0000, 16'h00E8, 0, 0);
    chk("R7 setup status", readSrc, 2);
    busWrite(16'h0456, 16'h0007, 0, 0);
    chk("R7 prog strobe", snapProg, 1);
    chk("R7 prog addr", snapAddr, 16'h0456);
    chk("R7 prog count", snapCount, 7);
    chk("R11 prog not early", earlyProg, 0);
    chk("R11 prog one cycle", lateProg, 0);
    busWrite(16'h0000, 16'h00E8, 0, 0);
    busWrite(16'h0800, 16'h001F, 0, 0);
    chk("R7 max count strobe", snapProg, 1);
    chk("R7 max count", snapCount, 31);
  endtask

  task automatic testAbort;
    busWrite(16'h0000, 16'h00E8, 0, 0);
    busWrite(16'h0900, 16'h0020, 0, 0);
    chk("R8 count too big no strobe", snapProg, 0);
    chk("R8 err set", statusErr, 1);
    chk("R8 array after abort", readSrc, 0);
    busWrite(16'h0000, 16'h0050, 0, 0);
    chk("R5 clear err", statusErr, 0);
    busWrite(16'h0000, 16'h0020, 0, 0);
    busWrite(16'h0300, 16'h0011, 0, 0);
    chk("R8 bad confirm no strobe", snapErase, 0);
    chk("R8 bad confirm err", statusErr, 1);
    chk("R8 bad confirm array", readSrc, 0);
    // sequencer must be idle again: a read-mode opcode now just switches source
    busWrite(16'h0000, 16'h0098, 0, 0);
    chk("R8 back to idle", readSrc, 3);
    busWrite(16'h0000, 16'h0050, 0, 0);
    chk("R5 clear err again", statusErr, 0);
  endtask

  task automatic testEnables;
    busWrite(16'h0000, 16'h0090, 1, 0);
    chk("R2 chip enable first", readSrc, 1);
    busWrite(16'h0000, 16'h0020, 1, 0);
    chk("R2 no duplicate command", readSrc, 2);
    busWrite(16'h0A00, 16'h00D0, 2, 16'h0B00);
    chk("R3 latch first strobe", snapErase, 1);
    chk("R3 latch first addr", snapAddr, 16'h0A00);
    busWrite(16'h0000, 16'h00FF, 0, 0);
    busWrite(16'h0000, 16'h0070, 3, 0);
    chk("R1 output enable low ignored", readSrc, 0);
    chk("R1 no strobe", snapErase | snapProg, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadModes();
    testUnknown();
    testErase();
    testProgram();
    testAbort();
    testEnables();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule